// File: doc/BRIEF.md
# On-Off-Keyed Symbol-Synchronous Relay Controller

This block is the digital core of one relay hop in a multi-hop link that uses pulse-based on-off keying: a symbol that carries a pulse is a '1', an empty symbol is a '0'. It runs on the sample clock and takes one received envelope magnitude per cycle. While idle it searches for a frame. The first sample above the magnitude threshold marks the start of a one-symbol preamble. That preamble fixes the symbol timing for the rest of the frame.

Each symbol period is split into three regions. The first is a detection window, where the block counts how many samples lie strictly above the threshold. The second is a fixed turnaround gap. The third is a forwarding region, where the transmitter is keyed if the symbol was judged a '1'. A hop therefore repeats every symbol within the same symbol period it arrived in. The added delay per hop is only the window plus the gap, not a whole frame. Decoded data bits come out MSB first. A switch control output moves the antenna path to transmit, and a single-cycle flag marks the end of each frame.

Symbol length, window length, gap length, hit count, threshold and frame length in bytes are run-time settings. They are accepted only while the block is searching. The defaults are 500-sample symbols (40 kbps at 20 MHz), a 200-sample window, a 100-sample gap and 4-byte frames. Settings must satisfy window + gap < symbol length, window >= 1 and frame bytes >= 1.

Top module: `ook_relay_ctrl`

## Requirements
- R1: While searching, the first sample strictly above the threshold is symbol sample 0 of the preamble. If the preamble window does not reach the hit count, the frame is dropped: no transmit, no switch, no strobe, no frame_done, and the block searches again.
- R2: A symbol is decided '1' exactly when the number of samples strictly above the threshold among its first window-length samples is at least the hit count. A sample equal to the threshold does not count.
- R3: tx_en is high only in symbol phases gap_start to symbol length - 1, where gap_start = window + gap, and only for a symbol decided '1'. This includes the preamble. tx_en is low during every detection window, during every gap and while searching.
- R4: trx_sel (1 = transmit path) is high from phase window to symbol length - 1 of a symbol decided '1', and low otherwise.
- R5: For each data symbol, bit_valid pulses for one cycle at phase window, with bit_out holding the decision. The preamble produces no strobe. Bits leave in frame order, MSB of the first byte first.
- R6: After the last sample of data symbol number frame_bytes*8, frame_done is high for exactly one cycle and the block is searching again. A preamble may start in that same cycle.
- R7: A configuration write (cfg_wr) takes effect only while the block is searching. A write during a frame is discarded, both for that frame and for later ones.
- R8: Synchronous reset clears all outputs and restores the default settings (500/200/100 samples, hit count 100, threshold 512, 4 bytes).
- R9: Frame lengths of 4 and 16 bytes are relayed with correct timing and bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_mag | input | 12 | Received envelope magnitude, one per cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sym_len | input | 16 | Samples per symbol |
| cfg_win_len | input | 16 | Detection window length in samples |
| cfg_gap_len | input | 16 | Turnaround gap length in samples |
| cfg_min_hits | input | 16 | Samples above threshold needed for a '1' |
| cfg_thresh | input | 12 | Magnitude threshold |
| cfg_frame_bytes | input | 6 | Data bytes per frame |
| bit_out | output | 1 | Decoded data bit |
| bit_valid | output | 1 | One-cycle strobe for bit_out |
| tx_en | output | 1 | Transmit pulse enable |
| trx_sel | output | 1 | Antenna switch, 1 = transmit |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
The bench checks the hit-count decision at its boundaries: exactly the required number of hits, one fewer, a magnitude equal to the threshold, and a pulse longer than the window. An off-by-one in the window or a non-strict compare would flip a decoded bit and add or drop a forwarded pulse. It checks tx_en and trx_sel against the expected phase every cycle. A design that miscounts the gap or the turnaround would key the transmitter one cycle early or late, or transmit while still listening.

A preamble one hit short must leave every output quiet. Frames are also sent back to back, so a new preamble arrives in the same cycle as frame_done. A design that needs an idle cycle after a frame would then lose symbol alignment. A configuration write in the middle of a frame must change nothing, neither in that frame nor in the next. A design that loads it anyway would shift every later symbol boundary.

// File: rtl/ook_relay_pkg.sv
package ook_relay_pkg;

  localparam int CNT_W = 16;  // phase, length and hit counters
  localparam int MAG_W = 12;  // envelope magnitude
  localparam int LEN_W = 6;   // frame length in bytes

  typedef enum logic [1:0] {
    ST_SEARCH   = 2'd0,
    ST_PREAMBLE = 2'd1,
    ST_DATA     = 2'd2
  } relay_state_t;

  typedef struct packed {
    logic [CNT_W-1:0] sym_len;
    logic [CNT_W-1:0] win_len;
    logic [CNT_W-1:0] buf_len;
    logic [CNT_W-1:0] min_hits;
    logic [MAG_W-1:0] thresh;
    logic [LEN_W-1:0] frame_bytes;
  } relay_cfg_t;

endpackage

// File: rtl/ook_cfg_regs.sv
module ook_cfg_regs
  import ook_relay_pkg::*;
#(
  parameter relay_cfg_t RESET_CFG = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  relay_cfg_t wr_cfg,
  output relay_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= RESET_CFG;
    end else if (load_en) begin
      cfg_q <= wr_cfg;
    end
  end

endmodule

// File: rtl/ook_sym_phase.sv
module ook_sym_phase
  import ook_relay_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] sym_len,
  output logic [CNT_W-1:0] ph_q,
  output logic [CNT_W-1:0] ph_nx,
  output logic             ph_last
);

  assign ph_last = (ph_q == sym_len - CNT_W'(1));

  always_comb begin
    if (!go) begin
      ph_nx = '0;
    end else if (ph_last) begin
      ph_nx = '0;
    end else begin
      ph_nx = ph_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_nx;
    end
  end

endmodule

// File: rtl/ook_win_detect.sv
module ook_win_detect
  import ook_relay_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             above,
  input  logic [CNT_W-1:0] ph,
  input  logic [CNT_W-1:0] win_len,
  input  logic [CNT_W-1:0] min_hits,
  output logic             decide,
  output logic             dec_bit
);

  logic [CNT_W-1:0] hits_q;
  logic [CNT_W-1:0] total;

  // Sample 0 of a symbol restarts the count.
  assign total   = ((ph == '0) ? '0 : hits_q) + CNT_W'(above);
  assign decide  = en && (ph == win_len - CNT_W'(1));
  assign dec_bit = (total >= min_hits);

  always_ff @(posedge clk) begin
    if (rst) begin
      hits_q <= '0;
    end else if (en && (ph < win_len)) begin
      hits_q <= total;
    end
  end

endmodule

// File: rtl/ook_relay_ctrl.sv
module ook_relay_ctrl
  import ook_relay_pkg::*;
#(
  parameter int DEF_SYM_LEN     = 500,
  parameter int DEF_WIN_LEN     = 200,
  parameter int DEF_GAP_LEN     = 100,
  parameter int DEF_MIN_HITS    = 100,
  parameter int DEF_THRESH      = 512,
  parameter int DEF_FRAME_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W-1:0] samp_mag,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_sym_len,
  input  logic [CNT_W-1:0] cfg_win_len,
  input  logic [CNT_W-1:0] cfg_gap_len,
  input  logic [CNT_W-1:0] cfg_min_hits,
  input  logic [MAG_W-1:0] cfg_thresh,
  input  logic [LEN_W-1:0] cfg_frame_bytes,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             tx_en,
  output logic             trx_sel,
  output logic             frame_done
);

  localparam int SC_W = LEN_W + 3;
  localparam relay_cfg_t RST_CFG = '{
    sym_len:     CNT_W'(DEF_SYM_LEN),
    win_len:     CNT_W'(DEF_WIN_LEN),
    buf_len:     CNT_W'(DEF_GAP_LEN),
    min_hits:    CNT_W'(DEF_MIN_HITS),
    thresh:      MAG_W'(DEF_THRESH),
    frame_bytes: LEN_W'(DEF_FRAME_BYTES)
  };

  relay_state_t     state_q, state_d;
  relay_cfg_t       wr_cfg, cfg_q;
  logic             load_en;
  logic             above, in_frame, go;
  logic [CNT_W-1:0] ph_q, ph_nx;
  logic             ph_last;
  logic             decide, dec_bit, bit_q, cur_bit;
  logic [SC_W-1:0]  sc_q, n_data;
  logic             last_data;
  logic [CNT_W:0]   guard_end, win_ext, nx_ext;

  // Write-side assembly of the settings.
  always_comb begin
    wr_cfg.sym_len     = cfg_sym_len;
    wr_cfg.win_len     = cfg_win_len;
    wr_cfg.buf_len     = cfg_gap_len;
    wr_cfg.min_hits    = cfg_min_hits;
    wr_cfg.thresh      = cfg_thresh;
    wr_cfg.frame_bytes = cfg_frame_bytes;
  end

  // Loads only while idle and not in the cycle a frame starts.
  assign load_en = cfg_wr && (state_q == ST_SEARCH) && (state_d == ST_SEARCH);

  ook_cfg_regs #(.RESET_CFG(RST_CFG)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .wr_cfg  (wr_cfg),
    .cfg_q   (cfg_q)
  );

  assign above    = (samp_mag > cfg_q.thresh);
  assign in_frame = (state_q != ST_SEARCH) || above;

  ook_win_detect det_i (
    .clk      (clk),
    .rst      (rst),
    .en       (in_frame),
    .above    (above),
    .ph       (ph_q),
    .win_len  (cfg_q.win_len),
    .min_hits (cfg_q.min_hits),
    .decide   (decide),
    .dec_bit  (dec_bit)
  );

  assign go = (state_d != ST_SEARCH);

  ook_sym_phase phase_i (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .sym_len (cfg_q.sym_len),
    .ph_q    (ph_q),
    .ph_nx   (ph_nx),
    .ph_last (ph_last)
  );

  assign n_data    = {cfg_q.frame_bytes, 3'b000};
  assign last_data = (sc_q == n_data - SC_W'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEARCH: begin
        if (above && !(decide && !dec_bit)) state_d = ST_PREAMBLE;
      end
      ST_PREAMBLE: begin
        if (decide && !dec_bit) state_d = ST_SEARCH;
        else if (ph_last)       state_d = ST_DATA;
      end
      ST_DATA: begin
        if (ph_last && last_data) state_d = ST_SEARCH;
      end
      default: state_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SEARCH;
    end else begin
      state_q <= state_d;
    end
  end

  // Data symbol counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      sc_q <= '0;
    end else if ((state_q == ST_PREAMBLE) && (state_d == ST_DATA)) begin
      sc_q <= '0;
    end else if ((state_q == ST_DATA) && ph_last) begin
      sc_q <= sc_q + SC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
    end else if (decide) begin
      bit_q <= dec_bit;
    end
  end

  assign cur_bit   = decide ? dec_bit : bit_q;
  assign win_ext   = {1'b0, cfg_q.win_len};
  assign guard_end = win_ext + {1'b0, cfg_q.buf_len};
  assign nx_ext    = {1'b0, ph_nx};

  // Registered outputs, each aligned to the phase held in the next cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en      <= 1'b0;
      trx_sel    <= 1'b0;
      bit_valid  <= 1'b0;
      bit_out    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      tx_en      <= go && cur_bit && (nx_ext >= guard_end);
      trx_sel    <= go && cur_bit && (nx_ext >= win_ext);
      bit_valid  <= decide && (state_q == ST_DATA);
      if (decide && (state_q == ST_DATA)) bit_out <= dec_bit;
      frame_done <= (state_q == ST_DATA) && ph_last && last_data;
    end
  end

endmodule

// File: rtl/ook_relay_chk.sv
module ook_relay_chk
  import ook_relay_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             trx_sel,
  input logic             bit_valid,
  input logic             frame_done,
  input logic [CNT_W-1:0] ph,
  input relay_cfg_t       cfg,
  input relay_state_t     state
);

  logic [CNT_W:0] guard;
  assign guard = {1'b0, cfg.win_len} + {1'b0, cfg.buf_len};

  AST_TX_AFTER_GUARD: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> ({1'b0, ph} >= guard)); // R3

  AST_NO_TX_SEARCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH) |-> !tx_en); // R3

  AST_TX_ON_TX_PATH: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> trx_sel); // R4

  AST_STROBE_AT_WIN: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (ph == cfg.win_len)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (state == ST_SEARCH)); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state != ST_SEARCH) |=> $stable(cfg)); // R7

endmodule

bind ook_relay_ctrl ook_relay_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .tx_en      (tx_en),
  .trx_sel    (trx_sel),
  .bit_valid  (bit_valid),
  .frame_done (frame_done),
  .ph         (ph_q),
  .cfg        (cfg_q),
  .state      (state_q)
);

// File: tb/ook_relay_ctrl_tb_top.sv
module ook_relay_ctrl_tb_top;
  import ook_relay_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MAXS       = 130;
  localparam int LOW_MAG    = 5;

  logic             clk = 1'b0;
  logic             rst;
  logic [MAG_W-1:0] samp_mag;
  logic             cfg_wr;
  logic [CNT_W-1:0] cfg_sym_len, cfg_win_len, cfg_gap_len, cfg_min_hits;
  logic [MAG_W-1:0] cfg_thresh;
  logic [LEN_W-1:0] cfg_frame_bytes;
  logic             bit_out, bit_valid, tx_en, trx_sel, frame_done;

  int n_tests = 0;
  int n_fail  = 0;
  int m_sym, m_win, m_gap, m_min, m_thr, m_bytes;
  int drv_plen [MAXS];
  int drv_mag  [MAXS];
  bit exp_bit  [MAXS];
  bit got_bits [MAXS];
  logic [7:0] fdata [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ook_relay_ctrl dut_i (
    .clk(clk), .rst(rst), .samp_mag(samp_mag), .cfg_wr(cfg_wr),
    .cfg_sym_len(cfg_sym_len), .cfg_win_len(cfg_win_len),
    .cfg_gap_len(cfg_gap_len), .cfg_min_hits(cfg_min_hits),
    .cfg_thresh(cfg_thresh), .cfg_frame_bytes(cfg_frame_bytes),
    .bit_out(bit_out), .bit_valid(bit_valid), .tx_en(tx_en),
    .trx_sel(trx_sel), .frame_done(frame_done)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int sym, input int win, input int gap,
                         input int mn, input int thr, input int nbytes);
    cfg_sym_len = CNT_W'(sym); cfg_win_len = CNT_W'(win);
    cfg_gap_len = CNT_W'(gap); cfg_min_hits = CNT_W'(mn);
    cfg_thresh = MAG_W'(thr); cfg_frame_bytes = LEN_W'(nbytes);
    cfg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
    m_sym = sym; m_win = win; m_gap = gap; m_min = mn; m_thr = thr; m_bytes = nbytes;
  endtask

  // Preamble plus data bits, MSB of fdata[0] first; '1' symbols get plen samples of mag.
  task automatic build_frame(input int nbytes, input int plen, input int mag);
    drv_plen[0] = plen; drv_mag[0] = mag;
    for (int i = 0; i < nbytes*8; i++) begin
      drv_plen[i+1] = fdata[i/8][7-(i%8)] ? plen : 0;
      drv_mag[i+1]  = mag;
    end
  endtask

  function automatic bit model_bit(input int s);
    int eff;
    eff = (drv_plen[s] < m_win) ? drv_plen[s] : m_win;
    return (drv_mag[s] > m_thr) && (eff >= m_min);
  endfunction

  task automatic play_frame(input string tag, input int nsym, input int tail,
                            input bit inject);
    int total_cyc = nsym * m_sym;
    int e_tx = 0, e_sel = 0, e_val = 0, e_done = 0, nb = 0, bad = 0;
    for (int s = 0; s < nsym; s++) exp_bit[s] = model_bit(s);
    for (int k = 0; k < total_cyc + tail; k++) begin
      int s = k / m_sym;
      int p = k % m_sym;
      int m = k + 1;
      int s2 = m / m_sym;
      int p2 = m % m_sym;
      bit x_tx, x_sel, x_val, x_done;
      if (k < total_cyc && p < drv_plen[s]) samp_mag = MAG_W'(drv_mag[s]);
      else samp_mag = MAG_W'(LOW_MAG);
      if (inject && k == total_cyc/2) begin
        cfg_sym_len = 16'd30; cfg_win_len = 16'd10; cfg_gap_len = 16'd5;
        cfg_min_hits = 16'd1; cfg_thresh = 12'd50; cfg_frame_bytes = 6'd2;
        cfg_wr = 1'b1;
      end else begin
        cfg_wr = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      x_tx = 0; x_sel = 0; x_val = 0; x_done = 0;
      if (m < total_cyc) begin
        x_tx  = exp_bit[s2] && (p2 >= m_win + m_gap);
        x_sel = exp_bit[s2] && (p2 >= m_win);
        x_val = (s2 >= 1) && (p2 == m_win);
      end else if (m == total_cyc) begin
        x_done = 1;
      end
      if (tx_en != x_tx) e_tx++;
      if (trx_sel != x_sel) e_sel++;
      if (bit_valid != x_val) e_val++;
      if (frame_done != x_done) e_done++;
      if (bit_valid) begin
        if (nb < MAXS) got_bits[nb] = bit_out;
        nb++;
      end
    end
    samp_mag = MAG_W'(LOW_MAG);
    cfg_wr = 1'b0;
    for (int i = 0; i < nsym - 1; i++) if (i < nb && got_bits[i] != exp_bit[i+1]) bad++;
    check("R3", e_tx == 0, {tag, " tx_en cycles wrong"}, e_tx, 0);
    check("R4", e_sel == 0, {tag, " trx_sel cycles wrong"}, e_sel, 0);
    check("R5", e_val == 0 && nb == nsym - 1, {tag, " bit strobe count"}, nb, nsym - 1);
    check("R2", bad == 0, {tag, " decoded bits wrong"}, bad, 0);
    check("R6", e_done == 0, {tag, " frame_done cycles wrong"}, e_done, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1; cfg_wr = 1'b0; samp_mag = MAG_W'(LOW_MAG);
    cfg_sym_len = '0; cfg_win_len = '0; cfg_gap_len = '0;
    cfg_min_hits = '0; cfg_thresh = '0; cfg_frame_bytes = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R8", {tx_en, trx_sel, bit_valid, bit_out, frame_done} == 5'b0,
          "outputs after reset", {tx_en, trx_sel, bit_valid, bit_out, frame_done}, 0);
    m_sym = 500; m_win = 200; m_gap = 100; m_min = 100; m_thr = 512; m_bytes = 4;
  endtask

  task automatic test_default_frame();  // R8 defaults, R9 4-byte frame
    fdata[0] = 8'hC3; fdata[1] = 8'h5A; fdata[2] = 8'h01; fdata[3] = 8'hFE;
    build_frame(4, 150, 900);
    play_frame("R9 default 4B", 33, 3, 0);
  endtask

  task automatic test_basic_small();
    fdata[0] = 8'hA5;
    build_frame(1, 6, 300);
    play_frame("basic", 9, 3, 0);
  endtask

  task automatic test_threshold();  // R2 hit-count and magnitude boundaries
    drv_plen[0] = 4;  drv_mag[0] = 300;   // preamble with exactly min hits
    drv_plen[1] = 4;  drv_mag[1] = 300;   // exactly min -> 1
    drv_plen[2] = 3;  drv_mag[2] = 300;   // one short -> 0
    drv_plen[3] = 8;  drv_mag[3] = 100;   // equal to threshold -> 0
    drv_plen[4] = 8;  drv_mag[4] = 101;   // just above -> 1
    drv_plen[5] = 12; drv_mag[5] = 300;   // longer than window -> 1
    drv_plen[6] = 0;  drv_mag[6] = 300;   // empty -> 0
    drv_plen[7] = 5;  drv_mag[7] = 300;   // -> 1
    drv_plen[8] = 3;  drv_mag[8] = 4095;  // strong but short -> 0
    play_frame("R2 threshold", 9, 3, 0);
    check("R2", exp_bit[1] && !exp_bit[2] && !exp_bit[3] && exp_bit[4],
          "bench model of boundary bits", 0, 0);
  endtask

  task automatic test_abort();  // R1
    int bad = 0;
    for (int k = 0; k < 3 * m_sym; k++) begin
      samp_mag = (k < m_min - 1) ? MAG_W'(300) : MAG_W'(LOW_MAG);
      @(posedge clk); @(negedge clk);
      if (tx_en || trx_sel || bit_valid || frame_done) bad++;
    end
    check("R1", bad == 0, "weak preamble produced activity", bad, 0);
    fdata[0] = 8'h3C;
    build_frame(1, 6, 300);
    play_frame("R1 after abort", 9, 3, 0);
  endtask

  task automatic test_cfg_ignored();  // R7
    fdata[0] = 8'h96;
    build_frame(1, 6, 300);
    play_frame("R7 write mid-frame", 9, 3, 1);
    fdata[0] = 8'h0F;
    build_frame(1, 6, 300);
    play_frame("R7 next frame old cfg", 9, 3, 0);
  endtask

  task automatic test_back_to_back();  // R6
    fdata[0] = 8'hFF;
    build_frame(1, 8, 300);
    play_frame("R6 b2b first", 9, 0, 0);
    fdata[0] = 8'h81;
    build_frame(1, 6, 300);
    play_frame("R6 b2b second", 9, 3, 0);
  endtask

  task automatic test_long_frame();  // R9 16-byte frame
    set_cfg(20, 8, 4, 4, 100, 16);
    for (int i = 0; i < 16; i++) fdata[i] = 8'((i * 37 + 11) & 255);
    build_frame(16, 7, 300);
    play_frame("R9 16B", 129, 3, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_default_frame();
    set_cfg(20, 8, 4, 4, 100, 1);
    test_basic_small();
    test_threshold();
    test_abort();
    test_cfg_ignored();
    test_back_to_back();
    test_long_frame();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule